// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block decides how a full-speed USB function answers each token sent to one of its endpoint pipes. Each pipe has its own set of status bits. The block compares the device address of the token with the programmed function address. It then checks that the endpoint number exists and that the pipe can serve the token's direction. From these results and the pipe's status bits it picks one answer for the packet engine: send data, ACK, NAK, STALL, a deliberate bit-stuff error followed by end of packet, or silence. It also reports which pipe FIFO the transfer uses, and it pulses a per-pipe receive-done event when OUT or SETUP data is accepted.

Pipe 0 is the bidirectional control pipe. Pipes 1 to `NUM_TX` carry IN traffic only. The next `NUM_RX` pipes carry OUT traffic only. The defaults give seven pipes. The packet engine presents a token for one cycle on `tok_valid`, and the registered answer appears on the next cycle. Line coding, CRC, bit stuffing and the FIFOs themselves belong to other blocks.

Top module: `usb_hs_responder`

## Requirements
- R1: A token whose `tok_addr` differs from `func_addr` gets no answer: `rsp_valid` stays 0 and `rx_done` stays 0.
- R2: A token gets no answer in any of these cases: its pipe is disabled, its endpoint number is at or above the number of pipes, or its kind is reserved (`tok_kind` 0). It also gets no answer when its kind does not suit the pipe: IN to a receive-only pipe, OUT to a transmit-only pipe, or SETUP to any pipe other than 0. Token kinds are 1 = OUT, 2 = IN, 3 = SETUP.
- R3: An accepted IN, OUT or SETUP token to a stalled pipe is answered with STALL (code 4). This takes precedence over the data and buffer bits.
- R4: An IN token to an unstalled pipe with data queued is answered with send-data (code 1), and `rsp_fifo` equals the endpoint number.
- R5: An IN token to an unstalled, non-isochronous pipe with no data is answered with NAK (code 3).
- R6: An IN token to an unstalled, isochronous pipe with no data is answered with bit-stuff error plus end of packet (code 5).
- R7: An OUT or SETUP token to an unstalled, non-isochronous pipe with a free buffer is answered with ACK (code 2). In the same cycle bit n of `rx_done` is set, where n is the endpoint number, and it stays set for exactly one cycle.
- R8: An OUT or SETUP token to an unstalled, non-isochronous pipe with no free buffer is answered with NAK (code 3) and leaves `rx_done` at 0.
- R9: An OUT token to an unstalled isochronous pipe is answered with silence (`rsp_valid` 1, code 0). `rx_done` pulses for that pipe only when its buffer is free.
- R10: The answer appears in the cycle after the token and lasts one cycle. During and right after reset, `rsp_valid`, `rsp_code`, `rsp_fifo` and `rx_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | 1 OUT, 2 IN, 3 SETUP, 0 reserved |
| tok_addr | input | ADDR_W | Device address carried by the token |
| tok_ep | input | EP_W | Endpoint number carried by the token |
| func_addr | input | ADDR_W | Programmed function address |
| ep_enable | input | NUM_EP | Per-pipe enable |
| ep_stall | input | NUM_EP | Per-pipe stall |
| ep_iso | input | NUM_EP | Per-pipe isochronous flag |
| ep_has_data | input | NUM_EP | Per-pipe transmit data queued |
| ep_buf_free | input | NUM_EP | Per-pipe receive buffer free |
| rsp_valid | output | 1 | Answer present |
| rsp_code | output | 3 | 0 silence, 1 data, 2 ACK, 3 NAK, 4 STALL, 5 bit-stuff error + EOP |
| rsp_fifo | output | IDX_W | Pipe FIFO selected for the transfer |
| rx_done | output | NUM_EP | One-cycle receive-complete event per pipe |

## Verification
Every result comes from a single register stage, so `rsp_valid`, `rsp_code`, `rsp_fifo` and `rx_done` are due one cycle after the token is presented. The bench drives each token on a falling edge and samples the outputs on the next falling edge, which lies after exactly one rising edge. Directed follow-ups sample one more falling edge later to confirm that the answer and the receive-done pulse have ended. A back-to-back pair of tokens confirms that each answer lands in its own cycle.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

    typedef enum logic [1:0] {
        TK_RSVD  = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_SETUP = 2'd3
    } tok_kind_e;

    typedef enum logic [2:0] {
        RC_SILENT   = 3'd0,
        RC_DATA     = 3'd1,
        RC_ACK      = 3'd2,
        RC_NAK      = 3'd3,
        RC_STALL    = 3'd4,
        RC_BITSTUFF = 3'd5
    } rsp_code_e;

endpackage

// File: rtl/usb_hs_ep_lookup.sv
module usb_hs_ep_lookup #(
    parameter int NUM_TX = 3,
    parameter int NUM_RX = 3,
    parameter int EP_W   = 4,
    localparam int NUM_EP = 1 + NUM_TX + NUM_RX
) (
    input  logic [EP_W-1:0] tok_ep,
    output logic            in_range,
    output logic            is_ctrl,
    output logic            can_in,
    output logic            can_out
);

    logic [NUM_EP-1:0] cap_in_v;
    logic [NUM_EP-1:0] cap_out_v;
    logic [NUM_EP-1:0] sh_in;
    logic [NUM_EP-1:0] sh_out;

    // Capability per pipe: 0 both ways, then transmit-only, then receive-only
    for (genvar g = 0; g < NUM_EP; g++) begin : g_cap
        assign cap_in_v[g]  = (g == 0) || (g <= NUM_TX);
        assign cap_out_v[g] = (g == 0) || (g > NUM_TX);
    end

    always_comb begin
        in_range = (tok_ep < EP_W'(NUM_EP));
        is_ctrl  = (tok_ep == '0);
        sh_in    = cap_in_v >> tok_ep;
        sh_out   = cap_out_v >> tok_ep;
        can_in   = in_range && sh_in[0];
        can_out  = in_range && sh_out[0];
    end

endmodule

// File: rtl/usb_hs_decide.sv
module usb_hs_decide
    import usb_hs_pkg::*;
(
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       addr_hit,
    input  logic       is_ctrl,
    input  logic       can_in,
    input  logic       can_out,
    input  logic       en,
    input  logic       st,
    input  logic       iso,
    input  logic       dat,
    input  logic       bfree,
    output logic       vld,
    output logic [2:0] code,
    output logic       rx_fire
);

    logic accept;
    logic is_in;

    always_comb begin
        is_in  = (tok_kind == TK_IN);
        accept = tok_valid && addr_hit && en &&
                 ((is_in && can_in) ||
                  ((tok_kind == TK_OUT) && can_out) ||
                  ((tok_kind == TK_SETUP) && is_ctrl));
        vld     = accept;
        code    = RC_SILENT;
        rx_fire = 1'b0;
        if (accept) begin
            if (st) begin
                code = RC_STALL;
            end else if (is_in) begin
                if (dat)      code = RC_DATA;
                else if (iso) code = RC_BITSTUFF;
                else          code = RC_NAK;
            end else begin
                if (bfree) begin
                    rx_fire = 1'b1;
                    code    = iso ? RC_SILENT : RC_ACK;
                end else begin
                    code    = iso ? RC_SILENT : RC_NAK;
                end
            end
        end
    end

endmodule

// File: rtl/usb_hs_responder.sv
module usb_hs_responder
    import usb_hs_pkg::*;
#(
    parameter int NUM_TX = 3,
    parameter int NUM_RX = 3,
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4,
    localparam int NUM_EP = 1 + NUM_TX + NUM_RX,
    localparam int IDX_W  = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic [ADDR_W-1:0] func_addr,
    input  logic [NUM_EP-1:0] ep_enable,
    input  logic [NUM_EP-1:0] ep_stall,
    input  logic [NUM_EP-1:0] ep_iso,
    input  logic [NUM_EP-1:0] ep_has_data,
    input  logic [NUM_EP-1:0] ep_buf_free,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [IDX_W-1:0]  rsp_fifo,
    output logic [NUM_EP-1:0] rx_done
);

    typedef struct packed {
        logic              vld;
        logic [2:0]        code;
        logic [IDX_W-1:0]  fifo;
        logic [NUM_EP-1:0] rxd;
    } out_t;

    out_t st_d, st_q;

    logic in_range, is_ctrl, can_in, can_out;
    logic dec_vld, dec_fire;
    logic [2:0] dec_code;
    logic [NUM_EP-1:0] sel_en, sel_st, sel_iso, sel_dat, sel_bf;

    usb_hs_ep_lookup #(.NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .EP_W(EP_W)) u_lookup (
        .tok_ep   (tok_ep),
        .in_range (in_range),
        .is_ctrl  (is_ctrl),
        .can_in   (can_in),
        .can_out  (can_out)
    );

    // Pick the addressed pipe's status bits by shifting it down to bit 0
    always_comb begin
        sel_en  = ep_enable   >> tok_ep;
        sel_st  = ep_stall    >> tok_ep;
        sel_iso = ep_iso      >> tok_ep;
        sel_dat = ep_has_data >> tok_ep;
        sel_bf  = ep_buf_free >> tok_ep;
    end

    usb_hs_decide u_decide (
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind),
        .addr_hit  (tok_addr == func_addr),
        .is_ctrl   (is_ctrl),
        .can_in    (can_in),
        .can_out   (can_out),
        .en        (sel_en[0] && in_range),
        .st        (sel_st[0]),
        .iso       (sel_iso[0]),
        .dat       (sel_dat[0]),
        .bfree     (sel_bf[0]),
        .vld       (dec_vld),
        .code      (dec_code),
        .rx_fire   (dec_fire)
    );

    always_comb begin
        st_d      = '0;
        st_d.vld  = dec_vld;
        if (dec_vld) begin
            st_d.code = dec_code;
            st_d.fifo = IDX_W'(tok_ep);
        end
        if (dec_fire) st_d.rxd = NUM_EP'(1) << tok_ep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_code  = st_q.code;
    assign rsp_fifo  = st_q.fifo;
    assign rx_done   = st_q.rxd;

    p_addr_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_addr != func_addr) |=> !rsp_valid);

    p_rxdone_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_done));

    p_rxdone_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_done) |-> (rsp_valid && (rsp_code == RC_ACK || rsp_code == RC_SILENT)));

    p_bitstuff_from_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_BITSTUFF) |-> ($past(tok_valid) && $past(tok_kind) == TK_IN));

    p_answer_follows_token_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(tok_valid));

    p_ep_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ep >= EP_W'(NUM_EP)) |=> !rsp_valid);

endmodule

// File: tb/tb_usb_hs_responder.sv
module tb_usb_hs_responder;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_EP = 7;
    localparam logic [6:0] FADDR = 7'h2A;
    localparam int NV = 20;

    // [16:15] kind [14:11] ep [10] addr match [9] en [8] stall [7] iso
    // [6] data [5] buf free [4] exp valid [3:1] exp code [0] exp rx_done
    localparam logic [16:0] VECS [NV] = '{
        {2'd2, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0}, // R4
        {2'd2, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0}, // R5
        {2'd2, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0}, // R6
        {2'd2, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0}, // R4
        {2'd2, 4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0}, // R3
        {2'd1, 4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1}, // R7
        {2'd1, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0}, // R8
        {2'd1, 4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0}, // R9
        {2'd1, 4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1}, // R9
        {2'd1, 4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0}, // R3
        {2'd3, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1}, // R7
        {2'd2, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0}, // R4
        {2'd2, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0}, // R1
        {2'd2, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0}, // R2
        {2'd2, 4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0}, // R2
        {2'd1, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R2
        {2'd3, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R2
        {2'd2, 4'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0}, // R2
        {2'd0, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0}, // R2
        {2'd1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0}  // R3
    };

    logic clk = 1'b0;
    logic rst_n;
    logic tok_valid;
    logic [1:0] tok_kind;
    logic [6:0] tok_addr, func_addr;
    logic [3:0] tok_ep;
    logic [NUM_EP-1:0] ep_enable, ep_stall, ep_iso, ep_has_data, ep_buf_free;
    logic rsp_valid;
    logic [2:0] rsp_code, rsp_fifo;
    logic [NUM_EP-1:0] rx_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_hs_responder dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_addr(tok_addr), .tok_ep(tok_ep), .func_addr(func_addr),
        .ep_enable(ep_enable), .ep_stall(ep_stall), .ep_iso(ep_iso),
        .ep_has_data(ep_has_data), .ep_buf_free(ep_buf_free),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_fifo(rsp_fifo),
        .rx_done(rx_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [16:0] v);
        tok_valid   = 1'b1;
        tok_kind    = v[16:15];
        tok_ep      = v[14:11];
        tok_addr    = v[10] ? FADDR : 7'h15;
        ep_enable   = {NUM_EP{v[9]}};
        ep_stall    = {NUM_EP{v[8]}};
        ep_iso      = {NUM_EP{v[7]}};
        ep_has_data = {NUM_EP{v[6]}};
        ep_buf_free = {NUM_EP{v[5]}};
    endtask

    task automatic expect_vec(input logic [16:0] v, input string req);
        logic [NUM_EP-1:0] erx;
        erx = v[0] ? (NUM_EP'(1) << v[14:11]) : '0;
        check({req, " valid"}, 32'(rsp_valid), 32'(v[4]));
        check({req, " rx_done"}, 32'(rx_done), 32'(erx));
        if (v[4]) begin
            check({req, " code"}, 32'(rsp_code), 32'(v[3:1]));
            check({req, " fifo"}, 32'(rsp_fifo), 32'(v[14:11]));
        end
    endtask

    initial begin
        rst_n = 1'b0; tok_valid = 1'b0; tok_kind = '0; tok_addr = '0; tok_ep = '0;
        func_addr = FADDR; ep_enable = '0; ep_stall = '0; ep_iso = '0;
        ep_has_data = '0; ep_buf_free = '0;
        repeat (3) @(negedge clk);
        // R10: outputs cleared by reset
        check("R10 reset valid", 32'(rsp_valid), 32'd0);
        check("R10 reset code", 32'(rsp_code), 32'd0);
        check("R10 reset rx_done", 32'(rx_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset valid", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            tok_valid = 1'b0;
            expect_vec(VECS[i], $sformatf("vec%0d", i));
        end

        // R7 / R10: ACK answer and rx_done pulse last exactly one cycle
        drive(VECS[5]);
        @(negedge clk);
        tok_valid = 1'b0;
        check("R7 rx_done pulse", 32'(rx_done), 32'h10);
        @(negedge clk);
        check("R7 rx_done cleared", 32'(rx_done), 32'd0);
        check("R10 answer one cycle", 32'(rsp_valid), 32'd0);

        // R10: back-to-back tokens each answered in their own cycle
        drive(VECS[0]);
        @(negedge clk);
        expect_vec(VECS[0], "R10 b2b first");
        drive(VECS[6]);
        @(negedge clk);
        tok_valid = 1'b0;
        expect_vec(VECS[6], "R10 b2b second");

        // R2: only the addressed pipe's enable matters
        drive(VECS[1]);
        ep_enable = 7'b1111011;
        @(negedge clk);
        tok_valid = 1'b0;
        check("R2 disabled pipe2", 32'(rsp_valid), 32'd0);

        // R8: SETUP with no free buffer on control pipe gets NAK
        drive({2'd3, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0});
        @(negedge clk);
        tok_valid = 1'b0;
        check("R8 setup nak code", 32'(rsp_code), 32'd3);
        check("R8 setup nak rx_done", 32'(rx_done), 32'd0);

        // R10: reset in the middle clears a pending answer
        drive(VECS[10]);
        @(negedge clk);
        tok_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset valid", 32'(rsp_valid), 32'd0);
        check("R10 mid reset rx_done", 32'(rx_done), 32'd0);
        rst_n = 1'b1;

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule